// File: doc/BRIEF.md
# NAND Flash Host Register Block

This block connects a processor's register bus to a raw NAND flash device. Software writes a control register that drives the flash command-latch, address-latch, chip-enable and write-protect pins. It moves data one byte at a time through a data port register. A single bus read of the data port can be 32 bits wide. In that case the block fetches two bytes from the flash, one after the other, and returns them in the two 16-bit halves of the word.

Every byte that crosses the data port, in either direction, also enters a Hamming ECC accumulator sized for 256-byte blocks. The accumulator keeps a byte counter, six column-parity bits and sixteen line-parity bits. Software reads these results through dedicated registers. The line parity comes back bit-interleaved across two registers. A write of any value to the clear register restarts the accumulation.

A small sequencer controls each bus request. It has five states:
- `S_IDLE` waits for a request.
- `S_PUT` issues one flash write strobe.
- `S_GET_LO` issues the first flash read strobe.
- `S_GET_HI` issues the second read strobe of a wide read.
- `S_ACK` returns the single-cycle acknowledge.

The sequencer has these transitions:
- From `S_IDLE`, a request goes to `S_PUT` for a data-port write, to `S_GET_LO` for a data-port read, and to `S_ACK` for any other offset.
- `S_PUT` goes to `S_ACK`.
- `S_GET_LO` goes to `S_GET_HI` on a wide read and to `S_ACK` otherwise.
- `S_GET_HI` goes to `S_ACK`.
- `S_ACK` goes to `S_IDLE`.

Top module: `nfh_host`

## Requirements
- R1: After reset, all flash control pins are low, the control register reads 0 apart from bit 5 (status), and the counter, column-parity and both line-parity registers read 0.
- R2: A write to offset 0x18 stores `bus_wbyte` with bit 5 forced to 0, and bits 7:6 read back as written. The pins decode the stored byte as follows: `fl_ce` = bit 0 OR bit 4, `fl_cle` = bit 1, `fl_ale` = bit 2, `fl_wp` = bit 3.
- R3: Bit 5 of a read of offset 0x18 equals the `fl_ready` input at the moment of the read. A written bit 5 has no effect.
- R4: A write to offset 0x14 gives exactly one `fl_we` strobe cycle with `fl_dout` = `bus_wbyte`. `bus_ack` follows in the next cycle.
- R5: A byte-wide read of offset 0x14 gives exactly one `fl_re` strobe. The sampled `fl_din` is returned in bits 7:0 and all other bits are 0.
- R6: A wide read of offset 0x14 gives two consecutive `fl_re` strobes. The first byte goes to bits 7:0, the second to bits 23:16, and all other bits are 0.
- R7: Each byte through the data port advances an 8-bit wrapping counter, which reads at offset 0x0C.
- R8: Column parity at offset 0x08 is the XOR over all fed bytes, bit by bit:
  - bit 0 covers byte bits 0,2,4,6 and bit 1 covers bits 1,3,5,7;
  - bit 2 covers bits 0,1,4,5 and bit 3 covers bits 2,3,6,7;
  - bit 4 covers bits 0–3 and bit 5 covers bits 4–7.
- R9: For a fed byte with odd parity, at counter value i:
  - line-parity byte A bit k toggles when bit k of i is 0;
  - line-parity byte B bit k toggles when bit k of i is 1.
  
  Offset 0x00 reads A[4+j] at bit 2j and B[4+j] at bit 2j+1. Offset 0x04 reads A[j] at bit 2j and B[j] at bit 2j+1 (j = 0..3).
- R10: A write of any value to offset 0x10 clears the counter and all parity bits.
- R11: A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x14 and 0x18 returns 0. A write to any offset other than 0x10, 0x14 and 0x18 changes neither the pins, the control register nor the ECC state.
- R12: A request is taken only in `S_IDLE`. `bus_ack` is a one-cycle pulse that comes 1 cycle after the request for register accesses, 2 cycles after for a data write or byte read, and 3 cycles after for a wide read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | One-cycle request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wbyte | input | 8 | Write data (low byte of the bus) |
| bus_wide | input | 1 | 32-bit access (data-port reads fetch two bytes) |
| bus_ack | output | 1 | Access complete |
| bus_rdata | output | DATA_W | Read data, valid with `bus_ack` |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_ce | output | 1 | Chip enable (OR of both enable bits) |
| fl_wp | output | 1 | Write protect |
| fl_we | output | 1 | Byte write strobe |
| fl_re | output | 1 | Byte read strobe |
| fl_dout | output | 8 | Byte to the flash |
| fl_din | input | 8 | Byte from the flash |
| fl_ready | input | 1 | Flash ready status |

## Verification
The bench writes all 256 control values, with `fl_ready` toggling, so that every pin decode and the status merge is tried against each bit on its own. The ECC is fed three ways:
- the ordered ramp 0..255, where line parity depends on each counter bit;
- a scattered pseudo-random stream;
- a mixed stream of byte and wide reads that runs past the 256-byte counter wrap.

Each is compared with parity computed bit by bit in the bench, so any swapped interleave lane or pairing shows up. Accesses to undefined offsets and to the clear register are followed by register reads and pin checks, which confirm that these accesses leave no side effect.

// File: rtl/nfh_pkg.sv
package nfh_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_PUT,
        S_GET_LO,
        S_GET_HI,
        S_ACK
    } seq_st_t;

    localparam logic [5:0] OFS_LPLO = 6'h00;
    localparam logic [5:0] OFS_LPHI = 6'h04;
    localparam logic [5:0] OFS_CP   = 6'h08;
    localparam logic [5:0] OFS_CNT  = 6'h0C;
    localparam logic [5:0] OFS_CLR  = 6'h10;
    localparam logic [5:0] OFS_IO   = 6'h14;
    localparam logic [5:0] OFS_CTL  = 6'h18;

    localparam int CTL_CE0 = 0;
    localparam int CTL_CLE = 1;
    localparam int CTL_ALE = 2;
    localparam int CTL_WP  = 3;
    localparam int CTL_CE1 = 4;
    localparam int CTL_RDY = 5;
endpackage

// File: rtl/nfh_ecc.sv
module nfh_ecc #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 8,
    localparam int SEL_W = $clog2(BYTE_W),
    localparam int CP_W  = 2 * SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              feed,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [IDX_W-1:0]  cnt,
    output logic [CP_W-1:0]   cp,
    output logic [IDX_W-1:0]  lp_a,
    output logic [IDX_W-1:0]  lp_b
);
    logic [CP_W-1:0] col_term;

    always_comb begin
        col_term = '0;
        for (int g = 0; g < SEL_W; g++) begin
            for (int p = 0; p < BYTE_W; p++) begin
                if (((p >> g) & 1) != 0) col_term[2*g+1] = col_term[2*g+1] ^ byte_in[p];
                else                     col_term[2*g]   = col_term[2*g]   ^ byte_in[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; cp <= '0; lp_a <= '0; lp_b <= '0;
        end else if (clr) begin
            cnt <= '0; cp <= '0; lp_a <= '0; lp_b <= '0;
        end else if (feed) begin
            cnt <= cnt + 1'b1;
            cp  <= cp ^ col_term;
            if (^byte_in) begin
                lp_a <= lp_a ^ ~cnt;
                lp_b <= lp_b ^ cnt;
            end
        end
    end

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (feed && !clr) |=> cnt == IDX_W'($past(cnt) + 1'b1));
    // R10
    ecc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0 && cp == '0 && lp_a == '0 && lp_b == '0));
    // R9
    lp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!feed && !clr) |=> ($stable(lp_a) && $stable(lp_b) && $stable(cp)));
endmodule

// File: rtl/nfh_lp_fmt.sv
module nfh_lp_fmt #(
    parameter int IDX_W = 8,
    localparam int HALF = IDX_W / 2
) (
    input  logic [IDX_W-1:0] lp_a,
    input  logic [IDX_W-1:0] lp_b,
    output logic [IDX_W-1:0] reg_lo,
    output logic [IDX_W-1:0] reg_hi
);
    for (genvar j = 0; j < HALF; j++) begin : g_lane
        assign reg_lo[2*j]   = lp_a[HALF+j];
        assign reg_lo[2*j+1] = lp_b[HALF+j];
        assign reg_hi[2*j]   = lp_a[j];
        assign reg_hi[2*j+1] = lp_b[j];
    end
endmodule

// File: rtl/nfh_seq.sv
module nfh_seq
    import nfh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic req_we,
    input  logic req_io,
    input  logic req_wide,
    output logic take,
    output logic put,
    output logic get,
    output logic get_hi,
    output logic ack
);
    seq_st_t st, st_nx;
    logic    wide_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            wide_l <= 1'b0;
        end else begin
            st <= st_nx;
            if (take) wide_l <= req_wide;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (req) begin
                    if (!req_io)     st_nx = S_ACK;
                    else if (req_we) st_nx = S_PUT;
                    else             st_nx = S_GET_LO;
                end
            end
            S_PUT:    st_nx = S_ACK;
            S_GET_LO: st_nx = wide_l ? S_GET_HI : S_ACK;
            S_GET_HI: st_nx = S_ACK;
            S_ACK:    st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    always_comb begin
        take   = (st == S_IDLE) && req;
        put    = (st == S_PUT);
        get    = (st == S_GET_LO) || (st == S_GET_HI);
        get_hi = (st == S_GET_HI);
        ack    = (st == S_ACK);
    end

    // R12
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R4
    put_then_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        put |=> (ack && !put));
    // R6
    wide_two_beats_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (get && !get_hi && wide_l) |=> (get && get_hi));
endmodule

// File: rtl/nfh_host.sv
module nfh_host
    import nfh_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 8,
    localparam int CP_W  = 2 * $clog2(BYTE_W),
    localparam int HI_LANE = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wbyte,
    input  logic              bus_wide,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic              fl_ce,
    output logic              fl_wp,
    output logic              fl_we,
    output logic              fl_re,
    output logic [BYTE_W-1:0] fl_dout,
    input  logic [BYTE_W-1:0] fl_din,
    input  logic              fl_ready
);
    logic              take, put, get, get_hi;
    logic [BYTE_W-1:0] ctl_q, wbyte_q;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] io_q;
    logic [IDX_W-1:0]  cnt, lp_a, lp_b, lp_reg_lo, lp_reg_hi;
    logic [CP_W-1:0]   cp;
    logic              req_io, ctl_wr, ecc_clr;

    assign req_io  = (bus_addr == ADDR_W'(OFS_IO));
    assign ctl_wr  = take && bus_we && (bus_addr == ADDR_W'(OFS_CTL));
    assign ecc_clr = take && bus_we && (bus_addr == ADDR_W'(OFS_CLR));

    nfh_seq u_seq (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .req_we(bus_we),
        .req_io(req_io), .req_wide(bus_wide), .take(take), .put(put),
        .get(get), .get_hi(get_hi), .ack(bus_ack)
    );

    nfh_ecc #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_ecc (
        .clk(clk), .rst_n(rst_n), .clr(ecc_clr), .feed(put || get),
        .byte_in(put ? wbyte_q : fl_din), .cnt(cnt), .cp(cp),
        .lp_a(lp_a), .lp_b(lp_b)
    );

    nfh_lp_fmt #(.IDX_W(IDX_W)) u_fmt (
        .lp_a(lp_a), .lp_b(lp_b), .reg_lo(lp_reg_lo), .reg_hi(lp_reg_hi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0; wbyte_q <= '0; addr_q <= '0; we_q <= 1'b0; io_q <= '0;
        end else begin
            if (take) begin
                addr_q  <= bus_addr;
                we_q    <= bus_we;
                wbyte_q <= bus_wbyte;
                io_q    <= '0;
            end
            if (ctl_wr) begin
                ctl_q <= bus_wbyte;
                ctl_q[CTL_RDY] <= 1'b0;
            end
            if (get && !get_hi) io_q[BYTE_W-1:0] <= fl_din;
            if (get_hi)         io_q[HI_LANE +: BYTE_W] <= fl_din;
        end
    end

    always_comb begin
        fl_cle  = ctl_q[CTL_CLE];
        fl_ale  = ctl_q[CTL_ALE];
        fl_wp   = ctl_q[CTL_WP];
        fl_ce   = ctl_q[CTL_CE0] | ctl_q[CTL_CE1];
        fl_we   = put;
        fl_re   = get;
        fl_dout = wbyte_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_ack && !we_q) begin
            case (addr_q)
                ADDR_W'(OFS_LPLO): bus_rdata[IDX_W-1:0] = lp_reg_lo;
                ADDR_W'(OFS_LPHI): bus_rdata[IDX_W-1:0] = lp_reg_hi;
                ADDR_W'(OFS_CP):   bus_rdata[CP_W-1:0]  = cp;
                ADDR_W'(OFS_CNT):  bus_rdata[IDX_W-1:0] = cnt;
                ADDR_W'(OFS_IO):   bus_rdata = io_q;
                ADDR_W'(OFS_CTL): begin
                    bus_rdata[BYTE_W-1:0] = ctl_q;
                    bus_rdata[CTL_RDY]    = fl_ready;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_we, fl_re, bus_ack}));
    // R11
    pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_wr |=> $stable({fl_cle, fl_ale, fl_ce, fl_wp}));
    // R5
    byte_read_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && !we_q && addr_q == ADDR_W'(OFS_IO)) |->
        (bus_rdata[DATA_W-1:HI_LANE+BYTE_W] == '0));
endmodule

// File: tb/tb_nfh_host.sv
module tb_nfh_host;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [7:0]  bus_wbyte = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic        fl_cle, fl_ale, fl_ce, fl_wp, fl_we, fl_re, fl_ready = 1'b0;
    logic [7:0]  fl_dout, fl_din;

    int total = 0, bad = 0;
    int rd_idx = 0, we_cnt = 0;
    logic [7:0] last_wr = '0;
    logic [7:0] fed [0:1023];
    int nfed = 0;
    logic [31:0] r;
    int lat;

    always #5 clk = ~clk;

    nfh_host dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wbyte(bus_wbyte), .bus_wide(bus_wide),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .fl_cle(fl_cle),
        .fl_ale(fl_ale), .fl_ce(fl_ce), .fl_wp(fl_wp), .fl_we(fl_we),
        .fl_re(fl_re), .fl_dout(fl_dout), .fl_din(fl_din), .fl_ready(fl_ready)
    );

    function automatic logic [7:0] flash_byte(int k);
        return 8'((k * 37 + 11) & 255);
    endfunction
    assign fl_din = flash_byte(rd_idx);

    always @(posedge clk) begin
        if (fl_re) rd_idx <= rd_idx + 1;
        if (fl_we) begin we_cnt <= we_cnt + 1; last_wr <= fl_dout; end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic [5:0] a, input logic [7:0] d,
                       input logic wd, output logic [31:0] rd, output int lt);
        bus_req = 1'b1; bus_we = w; bus_addr = a; bus_wbyte = d; bus_wide = wd;
        @(negedge clk);
        bus_req = 1'b0;
        lt = 1;
        while (!bus_ack && lt < 20) begin @(negedge clk); lt++; end
        rd = bus_rdata;
        @(negedge clk);
    endtask

    // expected parity from the requirement definitions
    task automatic ecc_expect(output logic [7:0] cnt_e, output logic [5:0] cp_e,
                              output logic [7:0] lo_e, output logic [7:0] hi_e);
        logic [7:0] pa, pb, b, ix;
        pa = '0; pb = '0; cp_e = '0;
        for (int i = 0; i < nfed; i++) begin
            b = fed[i]; ix = 8'(i & 255);
            for (int g = 0; g < 3; g++)
                for (int p = 0; p < 8; p++)
                    if (b[p]) begin
                        if (((p >> g) & 1) != 0) cp_e[2*g+1] = ~cp_e[2*g+1];
                        else                     cp_e[2*g]   = ~cp_e[2*g];
                    end
            if (^b)
                for (int k = 0; k < 8; k++) begin
                    if (ix[k]) pb[k] = ~pb[k]; else pa[k] = ~pa[k];
                end
        end
        for (int j = 0; j < 4; j++) begin
            lo_e[2*j] = pa[4+j]; lo_e[2*j+1] = pb[4+j];
            hi_e[2*j] = pa[j];   hi_e[2*j+1] = pb[j];
        end
        cnt_e = 8'(nfed & 255);
    endtask

    task automatic check_ecc(input string tag);
        logic [7:0] ce, le, he; logic [5:0] pe;
        ecc_expect(ce, pe, le, he);
        acc(1'b0, 6'h0C, 8'h00, 1'b0, r, lat); chk(r == {24'h0, ce}, {tag, " R7 count"}, r, {24'h0, ce});
        acc(1'b0, 6'h08, 8'h00, 1'b0, r, lat); chk(r == {26'h0, pe}, {tag, " R8 column"}, r, {26'h0, pe});
        acc(1'b0, 6'h00, 8'h00, 1'b0, r, lat); chk(r == {24'h0, le}, {tag, " R9 line low"}, r, {24'h0, le});
        acc(1'b0, 6'h04, 8'h00, 1'b0, r, lat); chk(r == {24'h0, he}, {tag, " R9 line high"}, r, {24'h0, he});
    endtask

    task automatic data_write(input logic [7:0] v);
        int w0;
        w0 = we_cnt;
        acc(1'b1, 6'h14, v, 1'b0, r, lat);
        fed[nfed] = v; nfed++;
        chk(we_cnt == w0 + 1 && last_wr == v && lat == 2, "R4 data write", {last_wr, 8'(we_cnt - w0), 8'(lat)}, {v, 8'd1, 8'd2});
    endtask

    task automatic ecc_clear(input logic [7:0] v);
        acc(1'b1, 6'h10, v, 1'b0, r, lat);
        nfed = 0;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] e;
        int k0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({fl_cle, fl_ale, fl_ce, fl_wp, fl_we, fl_re} == 6'b0, "R1 pins", {26'h0, fl_cle, fl_ale, fl_ce, fl_wp, fl_we, fl_re}, 0);
        acc(1'b0, 6'h18, 8'h00, 1'b0, r, lat); chk(r == 0, "R1 control", r, 0);
        chk(lat == 1, "R12 register latency", lat, 1);
        check_ecc("R1 reset");

        // R2 R3 exhaustive control sweep
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            fl_ready = b[0] ^ b[3];
            acc(1'b1, 6'h18, b, 1'b0, r, lat);
            chk({fl_ce, fl_cle, fl_ale, fl_wp} == {b[0] | b[4], b[1], b[2], b[3]}, "R2 pins",
                {28'h0, fl_ce, fl_cle, fl_ale, fl_wp}, {28'h0, b[0] | b[4], b[1], b[2], b[3]});
            acc(1'b0, 6'h18, 8'h00, 1'b0, r, lat);
            e = {24'h0, (b & 8'hDF) | {2'b0, fl_ready, 5'b0}};
            chk(r == e, "R3 control readback", r, e);
        end
        fl_ready = 1'b0;

        // R11 undefined offsets
        acc(1'b1, 6'h18, 8'h06, 1'b0, r, lat);
        data_write(8'h3C);
        for (int a = 0; a < 64; a++) begin
            logic [5:0] ad;
            ad = 6'(a);
            if (ad != 6'h10 && ad != 6'h14 && ad != 6'h18) acc(1'b1, ad, 8'hFF, 1'b1, r, lat);
        end
        chk({fl_ce, fl_cle, fl_ale, fl_wp} == 4'b0110, "R11 pins kept", {28'h0, fl_ce, fl_cle, fl_ale, fl_wp}, 32'h6);
        acc(1'b0, 6'h18, 8'h00, 1'b0, r, lat); chk(r == 32'h06, "R11 control kept", r, 32'h06);
        check_ecc("R11 ecc kept");
        foreach (fed[i]) if (i < 1) begin end
        for (int a = 0; a < 64; a++) begin
            logic [5:0] ad;
            ad = 6'(a);
            if (ad != 6'h00 && ad != 6'h04 && ad != 6'h08 && ad != 6'h0C && ad != 6'h14 && ad != 6'h18) begin
                acc(1'b0, ad, 8'h00, 1'b1, r, lat);
                chk(r == 0 && lat == 1, "R11 undefined read", r, 0);
            end
        end

        // R10 clear with arbitrary data
        ecc_clear(8'hA5);
        check_ecc("R10 after clear");

        // ramp 0..255 then scattered stream
        for (int i = 0; i < 256; i++) begin
            data_write(8'(i));
            if (i == 99) check_ecc("ramp mid");
        end
        check_ecc("ramp full");
        ecc_clear(8'h00);
        for (int i = 0; i < 37; i++) data_write(8'((i * 73 + 5) & 255));
        check_ecc("scatter");

        // R5 R6 reads
        ecc_clear(8'h77);
        for (int i = 0; i < 12; i++) begin
            k0 = rd_idx;
            acc(1'b0, 6'h14, 8'h00, 1'b0, r, lat);
            e = {24'h0, flash_byte(k0)};
            chk(r == e && rd_idx == k0 + 1 && lat == 2, "R5 byte read", r, e);
            fed[nfed] = flash_byte(k0); nfed++;
            k0 = rd_idx;
            acc(1'b0, 6'h14, 8'h00, 1'b1, r, lat);
            e = {8'h0, flash_byte(k0 + 1), 8'h0, flash_byte(k0)};
            chk(r == e && rd_idx == k0 + 2 && lat == 3, "R6 wide read", r, e);
            fed[nfed] = flash_byte(k0); nfed++;
            fed[nfed] = flash_byte(k0 + 1); nfed++;
        end
        check_ecc("reads");
        // run past the counter wrap
        for (int i = 0; i < 250; i++) data_write(8'((i * 29 + 200) & 255));
        check_ecc("wrap");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule